// File: doc/BRIEF.md
# Rotor-Frame Three-Phase PWM Modulator

This block takes a voltage command expressed in the rotating rotor frame (a direct and a quadrature component packed into one 32-bit word), plus the sine and cosine of the electrical angle, and turns it into three duty words for a three-phase inverter bridge. It rotates the command back into the stationary alpha/beta plane. It then splits that vector into three phase duties with a sector choice made from sign masks rather than branches. The result is clamped to the PWM period.

The three duties are stored in a small bank of transmit slots. A slot-info word selects which slot receives each phase. While writing, the block hands back what each slot held before, so a controller that runs once per PWM cycle gets last cycle's duties for its current reconstruction. A start strobe launches one conversion. A single-cycle done pulse marks that all three slot writes have landed.

Top module: `dq_svm_modulator`

## Requirements
- R1: After reset the three duty outputs, the three captured outputs, `done_o` and `busy_o` are all zero, and every slot holds zero.
- R2: The quadrature term is bits 15:0 of `dq_i`, sign-extended. The direct term is the whole of `dq_i` as a signed 32-bit value. With sine and cosine taken as signed 16-bit values, the block forms alpha = d·cos − q·sin and beta = d·sin + q·cos, each wrapped to 32 signed bits.
- R3: Let sb = 37837 × (beta >>> 16), wrapped to 32 bits. The mask case holds when alpha < 0 and (−alpha−1) − |sb| ≥ 0, with |sb| taken as −sb when beta < 0. In the mask case, phase 1 is 0, phase 2 is (sb − alpha) >>> 16 and phase 3 is (−sb − alpha) >>> 16. Otherwise, with beta ≥ 0: phase 2 is sb >>> 15, phase 3 is 0 and phase 1 is (alpha + sb) >>> 16. With beta < 0: phase 2 is 0, phase 3 is (−sb) >>> 15 and phase 1 is (alpha − sb) >>> 16.
- R4: Each phase value is clamped to the range 0 to the `period_i` value sampled with the accepted start, and appears in bits 13:0 of `duty1_o`/`duty2_o`/`duty3_o` for phases 1/2/3.
- R5: Bit 14 of each duty output, and of every word written to a slot, is a 1 enable flag once a conversion has completed.
- R6: The slot index for a write is the low log2(NSLOT) bits (bits 3:0 by default) of a byte of `slot_info_i`. Byte 0 selects the slot for phase 2, byte 1 the slot for phase 3, and byte 2 the slot for phase 1. Bits 31:24 have no effect.
- R7: Before each slot write, bits 13:0 of that slot's old word go to the captured output of the same phase (`prev2_o`, `prev3_o`, `prev1_o`). The writes go in the order phase 2, phase 3, phase 1, so a repeated index captures the word just written by an earlier phase.
- R8: A start sampled at a clock edge while idle gives `done_o` high for exactly one cycle, seven edges later. `busy_o` is high from the edge after the start through the done cycle.
- R9: A start asserted while `busy_o` is high is ignored. It neither changes the running conversion nor launches another one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Launch one conversion when idle |
| period_i | input | 14 | PWM period, upper clamp limit |
| dq_i | input | 32 | Packed rotor-frame command |
| sin_i | input | 16 | Sine of the electrical angle, signed |
| cos_i | input | 16 | Cosine of the electrical angle, signed |
| slot_info_i | input | 32 | Slot indices for phases 2, 3, 1 in bytes 0, 1, 2 |
| duty1_o | output | 15 | Phase 1 duty with enable flag in bit 14 |
| duty2_o | output | 15 | Phase 2 duty with enable flag in bit 14 |
| duty3_o | output | 15 | Phase 3 duty with enable flag in bit 14 |
| prev1_o | output | 14 | Old content of phase 1's slot |
| prev2_o | output | 14 | Old content of phase 2's slot |
| prev3_o | output | 14 | Old content of phase 3's slot |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The hardest case to reach is the mask sector: alpha must be negative and at least as large in magnitude as the scaled beta. Because the direct term reuses the quadrature bits, the command word has to be chosen so that both the wrapped products and the sign-extended q point the vector into that region. The stimulus includes commands with a negative packed word and a unit cosine, whose phase values are worked out by hand. Slot ordering is driven with info words whose bytes repeat or alias in their low bits, and with a non-zero top byte. That exposes both the capture order and the ignored fields at the captured outputs.

// File: rtl/svm_pkg.sv
package svm_pkg;

    localparam int WORD_W     = 32;
    localparam int TRIG_W     = 16;
    localparam int DUTY_W     = 14;
    localparam int SLOT_W     = DUTY_W + 1;
    localparam int NPH        = 3;
    localparam int BETA_SCALE = 37837;

    typedef logic signed [WORD_W-1:0] word_t;
    typedef logic [DUTY_W-1:0]        duty_t;
    typedef logic [SLOT_W-1:0]        slot_t;

    function automatic duty_t clamp_duty(input word_t v, input duty_t lim);
        word_t lim_w;
        lim_w = $signed({{(WORD_W-DUTY_W){1'b0}}, lim});
        if (v < 0)
            return '0;
        else if (v > lim_w)
            return lim;
        else
            return v[DUTY_W-1:0];
    endfunction

endpackage

// File: rtl/svm_rotate.sv
module svm_rotate
    import svm_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     in_valid,
    input  logic [WORD_W-1:0]        dq,
    input  logic signed [TRIG_W-1:0] sin_v,
    input  logic signed [TRIG_W-1:0] cos_v,
    output logic                     out_valid,
    output word_t                    alpha,
    output word_t                    beta
);

    typedef struct packed {
        logic  va;
        word_t p_dc;
        word_t p_qs;
        word_t p_ds;
        word_t p_qc;
        logic  vb;
        word_t alp;
        word_t bet;
    } rot_t;

    rot_t  r_q, r_d;
    word_t d_w, q_w, s_w, c_w;

    assign d_w = $signed(dq);
    assign q_w = {{(WORD_W-16){dq[15]}}, dq[15:0]};
    assign s_w = word_t'(sin_v);
    assign c_w = word_t'(cos_v);

    always_comb begin
        r_d    = r_q;
        r_d.va = in_valid;
        if (in_valid) begin
            r_d.p_dc = d_w * c_w;
            r_d.p_qs = q_w * s_w;
            r_d.p_ds = d_w * s_w;
            r_d.p_qc = q_w * c_w;
        end
        r_d.vb = r_q.va;
        if (r_q.va) begin
            r_d.alp = r_q.p_dc - r_q.p_qs;
            r_d.bet = r_q.p_ds + r_q.p_qc;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            r_q <= '0;
        else
            r_q <= r_d;
    end

    assign out_valid = r_q.vb;
    assign alpha     = r_q.alp;
    assign beta      = r_q.bet;

endmodule

// File: rtl/svm_split.sv
module svm_split
    import svm_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  word_t                 alpha,
    input  word_t                 beta,
    input  duty_t                 period,
    output logic                  out_valid,
    output logic                  duty_en,
    output logic [NPH-1:0][DUTY_W-1:0] duty
);

    typedef struct packed {
        logic  va;
        word_t alp;
        word_t sb;
        logic  bneg;
        logic  vb;
        logic  en;
        logic [NPH-1:0][DUTY_W-1:0] ph;
    } spl_t;

    spl_t  r_q, r_d;
    word_t beta_hi;
    word_t a_sgn, b_sgn, mag_diff, m_lt, sect;
    word_t t1, t2, t3, s1, s2, s3;

    assign beta_hi = beta >>> 16;

    always_comb begin
        a_sgn    = {WORD_W{r_q.alp[WORD_W-1]}};
        b_sgn    = {WORD_W{r_q.bneg}};
        mag_diff = (a_sgn ^ r_q.alp) - (b_sgn ^ (r_q.sb + b_sgn));
        m_lt     = {WORD_W{mag_diff[WORD_W-1]}};
        sect     = a_sgn & ~m_lt;

        t1 = r_q.alp & sect;
        t2 = r_q.sb - t1;
        t3 = -r_q.sb - t1;
        t2 = t2 & (~b_sgn | sect);
        t3 = t3 & (b_sgn | sect);
        t1 = (r_q.alp + t2 + t3) & ~sect;

        s1 = t1 >>> 16;
        if (sect[0]) begin
            s2 = t2 >>> 16;
            s3 = t3 >>> 16;
        end else begin
            s2 = t2 >>> 15;
            s3 = t3 >>> 15;
        end
    end

    always_comb begin
        r_d    = r_q;
        r_d.va = in_valid;
        if (in_valid) begin
            r_d.alp  = alpha;
            r_d.sb   = word_t'(BETA_SCALE) * beta_hi;
            r_d.bneg = beta[WORD_W-1];
        end
        r_d.vb = r_q.va;
        if (r_q.va) begin
            r_d.en    = 1'b1;
            r_d.ph[0] = clamp_duty(s1, period);
            r_d.ph[1] = clamp_duty(s2, period);
            r_d.ph[2] = clamp_duty(s3, period);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            r_q <= '0;
        else
            r_q <= r_d;
    end

    assign out_valid = r_q.vb;
    assign duty_en   = r_q.en;
    assign duty      = r_q.ph;

endmodule

// File: rtl/svm_slot_writer.sv
module svm_slot_writer
    import svm_pkg::*;
#(
    parameter int NSLOT = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       in_valid,
    input  logic [NPH-1:0][DUTY_W-1:0] duty,
    input  logic [WORD_W-1:0]          slot_info,
    output logic [NPH-1:0][DUTY_W-1:0] prev,
    output logic                       done
);

    localparam int SLOT_AW = $clog2(NSLOT);
    localparam int STEP_W  = $clog2(NPH);

    typedef struct packed {
        logic                       act;
        logic [STEP_W-1:0]          step;
        logic [NSLOT-1:0][SLOT_W-1:0] slots;
        logic [NPH-1:0][DUTY_W-1:0] cap;
        logic                       dn;
    } wr_t;

    wr_t r_q, r_d;

    logic [NPH-1:0][SLOT_AW-1:0] idx_of_step;
    logic [STEP_W-1:0]           cur;
    logic                        active;
    logic [SLOT_AW-1:0]          widx;
    int                          wph;
    logic                        unused_info_bits;

    for (genvar g = 0; g < NPH; g++) begin : g_idx
        assign idx_of_step[g] = slot_info[8*g +: SLOT_AW];
    end

    assign unused_info_bits = ^{slot_info[31:24],
                                slot_info[23:16+SLOT_AW],
                                slot_info[15:8+SLOT_AW],
                                slot_info[7:SLOT_AW]};

    function automatic int phase_of_step(input logic [STEP_W-1:0] s);
        case (s)
            2'd0:    return 1;
            2'd1:    return 2;
            default: return 0;
        endcase
    endfunction

    always_comb begin
        r_d    = r_q;
        r_d.dn = 1'b0;
        active = in_valid | r_q.act;
        cur    = in_valid ? '0 : r_q.step;
        widx   = idx_of_step[cur];
        wph    = phase_of_step(cur);
        if (active) begin
            r_d.cap[wph]   = r_q.slots[widx][DUTY_W-1:0];
            r_d.slots[widx] = {1'b1, duty[wph]};
            if (int'(cur) == NPH-1) begin
                r_d.act  = 1'b0;
                r_d.step = '0;
                r_d.dn   = 1'b1;
            end else begin
                r_d.act  = 1'b1;
                r_d.step = cur + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            r_q <= '0;
        else
            r_q <= r_d;
    end

    assign prev = r_q.cap;
    assign done = r_q.dn;

endmodule

// File: rtl/dq_svm_modulator.sv
module dq_svm_modulator
    import svm_pkg::*;
#(
    parameter int NSLOT = 16
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        start_i,
    input  logic [13:0] period_i,
    input  logic [31:0] dq_i,
    input  logic [15:0] sin_i,
    input  logic [15:0] cos_i,
    input  logic [31:0] slot_info_i,
    output logic [14:0] duty1_o,
    output logic [14:0] duty2_o,
    output logic [14:0] duty3_o,
    output logic [13:0] prev1_o,
    output logic [13:0] prev2_o,
    output logic [13:0] prev3_o,
    output logic        busy_o,
    output logic        done_o
);

    typedef struct packed {
        logic               busy;
        logic               go;
        duty_t              per;
        logic [WORD_W-1:0]  dq;
        logic [TRIG_W-1:0]  sn;
        logic [TRIG_W-1:0]  cs;
        logic [WORD_W-1:0]  info;
    } top_t;

    top_t r_q, r_d;

    logic                       rot_v, spl_v, spl_en, wr_done;
    word_t                      alpha, beta;
    logic [NPH-1:0][DUTY_W-1:0] duty, prev;

    always_comb begin
        r_d    = r_q;
        r_d.go = 1'b0;
        if (start_i && !r_q.busy) begin
            r_d.busy = 1'b1;
            r_d.go   = 1'b1;
            r_d.per  = period_i;
            r_d.dq   = dq_i;
            r_d.sn   = sin_i;
            r_d.cs   = cos_i;
            r_d.info = slot_info_i;
        end else if (wr_done) begin
            r_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            r_q <= '0;
        else
            r_q <= r_d;
    end

    svm_rotate u_rot (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (r_q.go),
        .dq        (r_q.dq),
        .sin_v     (r_q.sn),
        .cos_v     (r_q.cs),
        .out_valid (rot_v),
        .alpha     (alpha),
        .beta      (beta)
    );

    svm_split u_split (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (rot_v),
        .alpha     (alpha),
        .beta      (beta),
        .period    (r_q.per),
        .out_valid (spl_v),
        .duty_en   (spl_en),
        .duty      (duty)
    );

    svm_slot_writer #(.NSLOT(NSLOT)) u_wr (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (spl_v),
        .duty      (duty),
        .slot_info (r_q.info),
        .prev      (prev),
        .done      (wr_done)
    );

    assign duty1_o = {spl_en, duty[0]};
    assign duty2_o = {spl_en, duty[1]};
    assign duty3_o = {spl_en, duty[2]};
    assign prev1_o = prev[0];
    assign prev2_o = prev[1];
    assign prev3_o = prev[2];
    assign busy_o  = r_q.busy;
    assign done_o  = wr_done;

endmodule

// File: rtl/svm_checker.sv
module svm_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        start_i,
    input logic [13:0] period_i,
    input logic [14:0] duty1_o,
    input logic [14:0] duty2_o,
    input logic [14:0] duty3_o,
    input logic [13:0] prev1_o,
    input logic [13:0] prev2_o,
    input logic [13:0] prev3_o,
    input logic        busy_o,
    input logic        done_o
);

    logic [13:0] seen_per;

    always_ff @(posedge clk) begin
        if (!rst_n)
            seen_per <= '0;
        else if (start_i && !busy_o)
            seen_per <= period_i;
    end

    assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_done_in_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> busy_o);

    assert_accept_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> (busy_o && !done_o));

    assert_busy_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !done_o) |=> busy_o);

    assert_clamp_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (duty1_o[13:0] <= seen_per && duty2_o[13:0] <= seen_per
                    && duty3_o[13:0] <= seen_per));

    assert_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (duty1_o[14] && duty2_o[14] && duty3_o[14]));

    assert_capture_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |=> ($stable(prev1_o) && $stable(prev2_o) && $stable(prev3_o)));

endmodule

bind dq_svm_modulator svm_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .period_i    (period_i),
    .duty1_o     (duty1_o),
    .duty2_o     (duty2_o),
    .duty3_o     (duty3_o),
    .prev1_o     (prev1_o),
    .prev2_o     (prev2_o),
    .prev3_o     (prev3_o),
    .busy_o      (busy_o),
    .done_o      (done_o)
);

// File: tb/tb_dq_svm_modulator.sv
`timescale 1ns/1ps
module tb_dq_svm_modulator;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        st = 1'b0;
    logic [13:0] pr = '0;
    logic [31:0] dq = '0;
    logic [15:0] sn = '0;
    logic [15:0] cs = '0;
    logic [31:0] si = '0;
    logic [14:0] duty1, duty2, duty3;
    logic [13:0] prev1, prev2, prev3;
    logic        busy, done;

    int n_chk = 0;
    int n_bad = 0;
    int cyc   = 0;
    logic [14:0] slot_m [16];

    always #2 clk = ~clk;

    dq_svm_modulator dut (
        .clk(clk), .rst_n(rst_n), .start_i(st), .period_i(pr),
        .dq_i(dq), .sin_i(sn), .cos_i(cs), .slot_info_i(si),
        .duty1_o(duty1), .duty2_o(duty2), .duty3_o(duty3),
        .prev1_o(prev1), .prev2_o(prev2), .prev3_o(prev3),
        .busy_o(busy), .done_o(done)
    );

    typedef struct packed {
        logic [31:0] cmd;
        logic [15:0] s;
        logic [15:0] c;
        logic [31:0] info;
        logic [13:0] per;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{32'h0100FC18, 16'h2000, 16'h3000, 32'h00070503, 14'd2500},
        '{32'h00001388, 16'h5A82, 16'hA57E, 32'h00070503, 14'd2500},
        '{32'hFFFFB1E0, 16'h0000, 16'h7FFF, 32'h000A0B0C, 14'd3000},
        '{32'h00004E20, 16'h7FFF, 16'h0000, 32'h000C0B0A, 14'd16383},
        '{32'h0000F830, 16'h4000, 16'hC000, 32'hFF090909, 14'd2500},
        '{32'h12340BB8, 16'hE000, 16'h6000, 32'hFF132303, 14'd2500},
        '{32'h000007D0, 16'h7000, 16'h1000, 32'h00010203, 14'd100},
        '{32'h8000FFFF, 16'h9000, 16'hF000, 32'hA5FEDC0E, 14'd12000}
    };

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual %0d expected %0d", what, act, exp);
        end
    endtask

    function automatic void model(input logic [31:0] cmd, input logic [15:0] s,
                                  input logic [15:0] c,
                                  output logic signed [31:0] p1,
                                  output logic signed [31:0] p2,
                                  output logic signed [31:0] p3);
        logic signed [31:0] d, q, sv, cv, al, be, sb, absa, absb, t;
        d  = cmd;
        q  = {{16{cmd[15]}}, cmd[15:0]};
        sv = {{16{s[15]}}, s};
        cv = {{16{c[15]}}, c};
        al = d * cv - q * sv;
        be = d * sv + q * cv;
        sb = 32'sd37837 * (be >>> 16);
        absa = al[31] ? (-al - 32'sd1) : al;
        absb = be[31] ? -sb : sb;
        t    = absa - absb;
        if (al[31] && !t[31]) begin
            p1 = 0;
            p2 = (sb - al) >>> 16;
            p3 = (-sb - al) >>> 16;
        end else if (!be[31]) begin
            p2 = sb >>> 15;
            p3 = 0;
            p1 = (al + sb) >>> 16;
        end else begin
            p2 = 0;
            p3 = (-sb) >>> 15;
            p1 = (al - sb) >>> 16;
        end
    endfunction

    function automatic logic [13:0] clampb(input logic signed [31:0] v, input logic [13:0] per);
        if (v < 0) return 14'd0;
        if (v > $signed({18'd0, per})) return per;
        return v[13:0];
    endfunction

    task automatic run_op(input logic [31:0] cmd, input logic [15:0] s, input logic [15:0] c,
                          input logic [31:0] info, input logic [13:0] per, input bit interfere);
        int n;
        logic signed [31:0] r1, r2, r3;
        logic [14:0] e1, e2, e3;
        logic [13:0] ep1, ep2, ep3;
        int i0, i1, i2;
        @(negedge clk);
        dq = cmd; sn = s; cs = c; si = info; pr = per; st = 1'b1;
        @(negedge clk);
        st = 1'b0;
        n = 0;
        while (!done && n < 40) begin
            if (interfere && n == 2) begin
                st = 1'b1; dq = ~cmd; sn = ~s; si = ~info; pr = 14'd7;
            end else if (interfere && n == 3) begin
                st = 1'b0; dq = cmd; sn = s; si = info; pr = per;
            end
            @(negedge clk);
            n++;
        end
        st = 1'b0;
        chk("R8 done latency", n, 7);
        model(cmd, s, c, r1, r2, r3);
        e1 = {1'b1, clampb(r1, per)};
        e2 = {1'b1, clampb(r2, per)};
        e3 = {1'b1, clampb(r3, per)};
        i0 = int'(info[3:0]); i1 = int'(info[11:8]); i2 = int'(info[19:16]);
        ep2 = slot_m[i0][13:0]; slot_m[i0] = e2;
        ep3 = slot_m[i1][13:0]; slot_m[i1] = e3;
        ep1 = slot_m[i2][13:0]; slot_m[i2] = e1;
        chk("R2 R3 R4 R5 duty1", duty1, e1);
        chk("R2 R3 R4 R5 duty2", duty2, e2);
        chk("R2 R3 R4 R5 duty3", duty3, e3);
        chk("R6 R7 prev1", prev1, ep1);
        chk("R6 R7 prev2", prev2, ep2);
        chk("R6 R7 prev3", prev3, ep3);
        @(negedge clk);
        chk("R8 done one cycle", done, 0);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_bad++;
            n_chk++;
            $display("FAIL R8 watchdog actual %0d expected below %0d", cyc, 100000);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        for (int k = 0; k < 16; k++) slot_m[k] = '0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 duty1", duty1, 0);
        chk("R1 duty2", duty2, 0);
        chk("R1 duty3", duty3, 0);
        chk("R1 prev1", prev1, 0);
        chk("R1 prev2", prev2, 0);
        chk("R1 prev3", prev3, 0);
        chk("R1 busy", busy, 0);
        chk("R1 done", done, 0);

        // R2 hand-computed vector: alpha = beta = 16384000
        run_op(32'h000003E8, 16'h0000, 16'h4000, 32'h00070503, 14'd2500, 1'b0);
        chk("R2 phase1 value", duty1, 15'h4000 | 15'd394);
        chk("R2 phase2 value", duty2, 15'h4000 | 15'd288);
        chk("R2 phase3 value", duty3, 15'h4000);

        // table walk
        for (int v = 0; v < 8; v++)
            run_op(VECS[v].cmd, VECS[v].s, VECS[v].c, VECS[v].info, VECS[v].per, 1'b0);

        // R3 mask sector, unclamped
        run_op(32'hFFFFB1E0, 16'h0000, 16'h7FFF, 32'h00020100, 14'd16383, 1'b0);
        chk("R3 mask phase1", duty1, 15'h4000);
        chk("R3 mask phase2", duty2, 15'h4000 | 15'd4226);
        chk("R3 mask phase3", duty3, 15'h4000 | 15'd15773);

        // R4 same vector, clamped to period
        run_op(32'hFFFFB1E0, 16'h0000, 16'h7FFF, 32'h00020100, 14'd2500, 1'b0);
        chk("R4 clamp phase2", duty2, 15'h4000 | 15'd2500);
        chk("R4 clamp phase3", duty3, 15'h4000 | 15'd2500);
        chk("R7 capture of earlier run", prev3, 14'd15773);

        // R9 start during busy is ignored
        run_op(32'h00000BB8, 16'h1800, 16'h6000, 32'h00040506, 14'd2500, 1'b1);
        begin
            int seen = 0;
            for (int k = 0; k < 12; k++) begin
                @(negedge clk);
                if (done || busy) seen++;
            end
            chk("R9 no second run", seen, 0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule